// File: doc/BRIEF.md
# Modem Disable Tone Detector Controller

This block holds the timing and state logic that decides when a modem disable tone has been found on one voice path, and when that finding is withdrawn. A channel uses two instances: one watches the receive input and one watches the send input. An upstream analysis stage supplies per-sample flags on an 8 kHz strobe. Those flags say whether the tone is in band and inside each of two level windows, whether a phase reversal was seen, and whether each path's band energies are under the release thresholds. Filtering, level measurement and reversal detection are not part of this block.

The controller accepts a tone under two rules. The reversal rule needs one second of continuous tone in the narrower level window, with at least one reversal. The plain rule needs 400 ms of continuous tone in the wider level window. A two-bit mode input selects which rules count. After a trigger the status output latches and no longer needs the tone. It clears only when both paths have been quiet for 400 ms without a break. Each change of status pulls the active-low interrupt request low, and it stays low until a clear pulse arrives.

Top module: `tone_guard_ctrl`

## Requirements
- R1: After reset, `tone_found` is 0 and `irq_n` is 1.
- R2: When `accept_mode[1]` is 1 (encodings 2'b10 and 2'b11), `tone_found` rises at the clock edge that samples the PLAIN_RUN-th consecutive strobe with `tone_wide`=1. A strobe with `tone_wide`=0 restarts the run.
- R3: When `accept_mode[0]` is 1 (encodings 2'b01 and 2'b11), `tone_found` rises at the edge that samples the REV_RUN-th consecutive strobe with `tone_narrow`=1, if `rev_evt` was 1 on at least one strobe of that run. A strobe with `tone_narrow`=0 clears both the run and the reversal memory.
- R4: Mode encoding: 2'b00 accepts no rule, 2'b01 accepts only the reversal rule, 2'b10 accepts only the plain rule, and 2'b11 accepts either rule.
- R5: Once `tone_found` is 1, it stays 1 whatever the tone flags do. Only the release of R6 clears it.
- R6: With `tone_found`=1, the output falls at the edge that samples the QUIET_RUN-th consecutive strobe with both `quiet_rx`=1 and `quiet_tx`=1. A strobe with either flag at 0 restarts the run.
- R7: At the same edge where `tone_found` changes in either direction, `irq_n` goes to 0. It stays 0 until an edge where `irq_clr` is 1 and no status change happens.
- R8: If `irq_clr` is 1 at the same edge as a status change, the change wins and `irq_n` stays 0.
- R9: Only cycles with `smp_stb`=1 advance or restart the runs. The flags are ignored in all other cycles, and `tone_found` does not change there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle 8 kHz sample strobe |
| tone_narrow | input | 1 | Tone in band, level within the reversal-rule window |
| tone_wide | input | 1 | Tone in band, level within the plain-rule window |
| rev_evt | input | 1 | Phase reversal seen on this sample |
| quiet_rx | input | 1 | Receive path under both release thresholds |
| quiet_tx | input | 1 | Send path under both release thresholds |
| accept_mode | input | 2 | Accepted rules, encoding per R4 |
| irq_clr | input | 1 | Clears a pending interrupt |
| tone_found | output | 1 | Latched detection status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can land on the same edge: a status change that raises an interrupt, and a clear pulse on `irq_clr` that withdraws one. A directed step puts the clear pulse on exactly the strobe that completes a release. The random phase also pulses the clear input on about one cycle in sixteen, while triggers and releases happen often. In both cases `irq_n` must stay low after the collision, and a bench model built from the requirements predicts the status and interrupt level every cycle.

// File: rtl/tg_pkg.sv
// Shared types and helpers for the disable tone controller.
// Assumes the sample strobe runs at SAMPLE_HZ.
package tg_pkg;

    // Which acceptance rules may trigger detection
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_REV   = 2'b01,
        ACC_PLAIN = 2'b10,
        ACC_ANY   = 2'b11
    } acc_mode_e;

    localparam int unsigned SAMPLE_HZ = 8000;

    // Converts a duration in milliseconds to a count of strobes
    function automatic int unsigned ms_to_samples(input int unsigned ms);
        return (ms * SAMPLE_HZ) / 1000;
    endfunction

endpackage

// File: rtl/tg_run_timer.sv
// Counts consecutive qualifying strobes and reports when a run of
// LIMIT strobes completes. With NEED_MARK set, the run must also
// contain at least one strobe with `mark` high. A strobe with `qual`
// low, or any strobe while `hold` is high, clears the run.
// Assumes LIMIT >= 1. The count saturates at LIMIT, so `hit` repeats
// on each further qualifying strobe until something consumes it.
module tg_run_timer #(
    parameter int unsigned LIMIT     = 3200,
    parameter bit          NEED_MARK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic hold,
    input  logic qual,
    input  logic mark,
    output logic hit
);
    localparam int unsigned CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          seen_q;
    logic          run_full;
    logic          mark_ok;

    // This strobe completes the run when the count so far is LIMIT-1 or more
    assign run_full = ({1'b0, cnt_q} + (CW+1)'(1)) >= (CW+1)'(LIMIT);
    // Reversal memory counts only in the variant that needs it
    assign mark_ok  = NEED_MARK ? (seen_q | mark) : 1'b1;
    assign hit      = stb & ~hold & qual & run_full & mark_ok;

    // Advance or clear the run on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (stb) begin
            if (hold || !qual) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                if (cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
                seen_q <= seen_q | mark;
            end
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
    p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(cnt_q) && $stable(seen_q)));
    p_drop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !qual) |=> (cnt_q == '0 && !seen_q));

endmodule

// File: rtl/tg_irq_flag.sv
// Pending-interrupt flag. It is set by a status change event and
// cleared by a clear pulse. When both arrive in the same cycle, the
// event wins. The request output is active low.
module tg_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic irq_n
);
    logic pend_q;

    // Hold the pending flag: a new event takes priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (evt) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !irq_n);
    p_clr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> irq_n);
    p_low_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr) |=> !irq_n);

endmodule

// File: rtl/tone_guard_ctrl.sv
// Disable tone detector controller for one voice path.
// It combines the reversal rule, the plain rule and the quiet-release
// timer into a latched status bit, and raises an active-low interrupt
// on every change of that bit.
// Assumes the upstream flags are valid on cycles where smp_stb is high.
module tone_guard_ctrl #(
    parameter int unsigned PLAIN_RUN = tg_pkg::ms_to_samples(400),
    parameter int unsigned REV_RUN   = tg_pkg::ms_to_samples(1000),
    parameter int unsigned QUIET_RUN = tg_pkg::ms_to_samples(400)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       tone_narrow,
    input  logic       tone_wide,
    input  logic       rev_evt,
    input  logic       quiet_rx,
    input  logic       quiet_tx,
    input  logic [1:0] accept_mode,
    input  logic       irq_clr,
    output logic       tone_found,
    output logic       irq_n
);
    import tg_pkg::*;

    acc_mode_e mode_e;
    logic      status_q, status_d;
    logic      rev_hit, plain_hit, rel_hit;
    logic      trig;
    logic      both_quiet;

    assign mode_e     = acc_mode_e'(accept_mode);
    assign both_quiet = quiet_rx & quiet_tx;

    tg_run_timer #(.LIMIT(REV_RUN), .NEED_MARK(1'b1)) i_rev_run (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .hold(status_q),
        .qual(tone_narrow), .mark(rev_evt), .hit(rev_hit));

    tg_run_timer #(.LIMIT(PLAIN_RUN), .NEED_MARK(1'b0)) i_plain_run (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .hold(status_q),
        .qual(tone_wide), .mark(1'b0), .hit(plain_hit));

    tg_run_timer #(.LIMIT(QUIET_RUN), .NEED_MARK(1'b0)) i_quiet_run (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .hold(~status_q),
        .qual(both_quiet), .mark(1'b0), .hit(rel_hit));

    // Gate each rule's completion by the selected mode
    always_comb begin
        trig = 1'b0;
        unique case (mode_e)
            ACC_NONE:  trig = 1'b0;
            ACC_REV:   trig = rev_hit;
            ACC_PLAIN: trig = plain_hit;
            ACC_ANY:   trig = rev_hit | plain_hit;
        endcase
    end

    // Next status: latch on a trigger, drop only on a quiet release
    always_comb begin
        status_d = status_q;
        if (!status_q && trig)        status_d = 1'b1;
        else if (status_q && rel_hit) status_d = 1'b0;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= status_d;
    end

    tg_irq_flag i_irq (
        .clk(clk), .rst_n(rst_n), .evt(status_d != status_q),
        .clr(irq_clr), .irq_n(irq_n));

    assign tone_found = status_q;

    p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(smp_stb && both_quiet)) |=> status_q);
    p_mode_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q && mode_e == ACC_NONE) |=> !status_q);
    p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(status_q));
    p_irq_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != $past(status_q)) |-> !irq_n);

endmodule

// File: tb/test_tone_guard_ctrl.sv
// Bench for tone_guard_ctrl: directed corner cases, then seeded random
// segments, checked against a model built from the requirements.
module test_tone_guard_ctrl;
    localparam int PLAIN = 12;
    localparam int REV   = 30;
    localparam int QUIET = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 0, narrow = 0, wide = 0, rev = 0, qrx = 0, qtx = 0, clr = 0;
    logic [1:0] mode = 2'b00;
    logic tone_found, irq_n;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tone_guard_ctrl #(.PLAIN_RUN(PLAIN), .REV_RUN(REV), .QUIET_RUN(QUIET)) i_tone_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .tone_narrow(narrow),
        .tone_wide(wide), .rev_evt(rev), .quiet_rx(qrx), .quiet_tx(qtx),
        .accept_mode(mode), .irq_clr(clr), .tone_found(tone_found), .irq_n(irq_n));

    // Requirement model state
    int m_rc, m_pc, m_qc;
    bit m_rs, m_st, m_pend;

    // Model update at each edge, following R2..R9
    always @(posedge clk) begin
        bit rf, pf, lf, ns;
        if (!rst_n) begin
            m_rc = 0; m_pc = 0; m_qc = 0; m_rs = 0; m_st = 0; m_pend = 0;
        end else begin
            ns = m_st;
            if (stb) begin
                rf = !m_st && narrow && (m_rc + 1 >= REV) && (m_rs || rev);
                pf = !m_st && wide && (m_pc + 1 >= PLAIN);
                lf = m_st && qrx && qtx && (m_qc + 1 >= QUIET);
                if (m_st) ns = !lf;
                else      ns = (rf && mode[0]) || (pf && mode[1]);
                if (m_st || !narrow) begin m_rc = 0; m_rs = 0; end
                else begin if (m_rc < REV) m_rc++; m_rs = m_rs | rev; end
                if (m_st || !wide) m_pc = 0;
                else if (m_pc < PLAIN) m_pc++;
                if (!m_st || !(qrx && qtx)) m_qc = 0;
                else if (m_qc < QUIET) m_qc++;
            end
            if (ns != m_st) m_pend = 1;
            else if (clr)   m_pend = 0;
            m_st = ns;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 R5 R6 status vs model", tone_found, m_st);
            chk("R7 R8 irq_n vs model", irq_n, !m_pend);
        end
    end

    task automatic step(input bit s, input bit n, input bit w, input bit r,
                        input bit qr, input bit qt, input bit c);
        stb = s; narrow = n; wide = w; rev = r; qrx = qr; qtx = qt; clr = c;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seedv;
        seedv = $urandom(32'd1357);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 reset status", tone_found, 1'b0);
        chk("R1 reset irq_n", irq_n, 1'b1);
        rst_n = 1'b1;

        // R2: plain rule, exact run length
        mode = 2'b10;
        repeat (PLAIN - 1) step(1,0,1,0,0,0,0);
        step(1,0,0,0,0,0,0);
        chk("R2 broken run", tone_found, 1'b0);
        repeat (PLAIN - 1) step(1,0,1,0,0,0,0);
        chk("R2 one short", tone_found, 1'b0);
        step(1,0,1,0,0,0,0);
        chk("R2 trigger", tone_found, 1'b1);
        chk("R7 irq on set", irq_n, 1'b0);
        repeat (20) step(1,0,0,0,0,0,0);
        chk("R5 latched without tone", tone_found, 1'b1);
        chk("R7 irq held", irq_n, 1'b0);
        step(0,0,0,0,0,0,1);
        chk("R7 irq cleared", irq_n, 1'b1);

        // R6: release needs both paths quiet without a break
        repeat (QUIET - 1) step(1,0,0,0,1,1,0);
        step(1,0,0,0,1,0,0);
        repeat (QUIET - 1) step(1,0,0,0,1,1,0);
        chk("R6 broken quiet", tone_found, 1'b1);
        step(1,0,0,0,1,1,0);
        chk("R6 release", tone_found, 1'b0);
        chk("R7 irq on release", irq_n, 1'b0);
        step(0,0,0,0,0,0,1);

        // R3: reversal rule
        mode = 2'b01;
        repeat (REV) step(1,1,1,0,0,0,0);
        chk("R3 no reversal", tone_found, 1'b0);
        step(1,0,0,0,0,0,0);
        repeat (4) step(1,1,0,0,0,0,0);
        step(1,1,0,1,0,0,0);
        repeat (REV - 6) step(1,1,0,0,0,0,0);
        chk("R3 one short", tone_found, 1'b0);
        step(1,1,0,0,0,0,0);
        chk("R3 trigger", tone_found, 1'b1);
        step(0,0,0,0,0,0,1);

        // R8: clear on the releasing edge
        repeat (QUIET - 1) step(1,0,0,0,1,1,0);
        step(1,0,0,0,1,1,1);
        chk("R8 status released", tone_found, 1'b0);
        chk("R8 change beats clear", irq_n, 1'b0);
        step(0,0,0,0,0,0,1);
        chk("R8 later clear", irq_n, 1'b1);

        // R4: mode 00 blocks, 11 accepts either
        mode = 2'b00;
        repeat (REV + 10) step(1,1,1,1,0,0,0);
        chk("R4 mode none", tone_found, 1'b0);
        mode = 2'b11;
        step(1,0,0,0,0,0,0);
        repeat (PLAIN) step(1,0,1,0,0,0,0);
        chk("R4 mode any plain", tone_found, 1'b1);
        step(0,0,0,0,0,0,1);

        // R9: non-strobe cycles ignored
        repeat (QUIET - 1) step(1,0,0,0,1,1,0);
        repeat (20) step(0,0,0,0,0,0,0);
        chk("R9 gap keeps status", tone_found, 1'b1);
        step(1,0,0,0,1,1,0);
        chk("R9 release after gap", tone_found, 1'b0);
        step(0,0,0,0,0,0,1);
        mode = 2'b10;
        repeat (6) step(1,0,1,0,0,0,0);
        repeat (15) step(0,0,0,0,0,0,0);
        repeat (PLAIN - 7) step(1,0,1,0,0,0,0);
        chk("R9 gap in tone run", tone_found, 1'b0);
        step(1,0,1,0,0,0,0);
        chk("R9 trigger after gap", tone_found, 1'b1);

        // Random segments
        for (int seg = 0; seg < 300; seg++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) mode = 2'($urandom_range(0, 3));
            for (int k = 0; k < 60; k++) begin
                bit s, n, w, r, qr, qt, c;
                s = ($urandom_range(0, 7) != 0);
                c = ($urandom_range(0, 15) == 0);
                n = 0; w = 0; r = 0; qr = 0; qt = 0;
                case (kind)
                    0: begin n = ($urandom_range(0, 39) != 0); w = ($urandom_range(0, 39) != 0); end
                    1: begin n = ($urandom_range(0, 59) != 0); r = ($urandom_range(0, 19) == 0); end
                    2: begin qr = ($urandom_range(0, 24) != 0); qt = ($urandom_range(0, 24) != 0); end
                    default: begin
                        n = 1'($urandom); w = 1'($urandom); r = 1'($urandom);
                        qr = 1'($urandom); qt = 1'($urandom);
                    end
                endcase
                step(s, n, w, r, qr, qt, c);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule